// File: doc/BRIEF.md
# Nibble Arithmetic and Compare-Skip Unit

This unit executes the arithmetic and compare group of a 4-bit controller. One 16-bit instruction word is handed over with a one-cycle issue strobe, together with the register nibble, the memory nibble and the current carry/borrow flag. The unit decodes the 6-bit major opcode in bits 15:10 and does one of two things. It can add or subtract two 4-bit operands, optionally consuming the flag as carry-in or borrow-in, and write the result to the register or to the memory destination. It can also compare two operands without writing anything. The outcome of either kind of instruction can raise a request to skip the next instruction.

Operands come in two shapes. A register-form instruction pairs the register nibble with the memory nibble, and its result goes to the register. An immediate-form instruction pairs the memory nibble with the immediate in bits 3:0, and its result goes back to memory. Bits 9:8 give the memory row and bits 7:4 the memory column. Bits 3:0 are the register number in register form and the immediate in immediate form. The destination fields leave the unit together with the result.

A two-state machine sequences the work. In ST_IDLE no result is presented. An issue moves the machine to ST_RETIRE (transition T_ISSUE). In ST_RETIRE the registered result, the write enables, the flag and the skip are presented for exactly that cycle. Another issue keeps the machine in ST_RETIRE (T_CHAIN). No issue returns it to ST_IDLE (T_DRAIN).

Top module: `nalu_core`

## Requirements
- R1: After reset `done`, `reg_we`, `mem_we`, `carry_we` and `skip` are all 0.
- R2: Opcodes 010000, 010001, 010010 and 010011 compute register + memory, adding the flag as carry-in only when opcode bit 1 is 1. The low 4 bits go to `result` with `reg_we`=1 and `mem_we`=0, and `carry_out` is the carry from bit 3.
- R3: Opcodes 010100 to 010111 compute memory + immediate (instr[3:0]) with the same carry-in rule. The result goes to memory with `mem_we`=1 and `reg_we`=0.
- R4: Opcodes 011000 to 011011 compute register − memory, subtracting the flag as borrow-in only when opcode bit 1 is 1. The result goes to the register, and `carry_out` is 1 exactly when a borrow occurs.
- R5: Opcodes 011100 to 011111 compute memory − immediate with the same borrow-in rule. The result goes to memory.
- R6: Every arithmetic opcode (0100xx to 0111xx) asserts `carry_we`, whatever its skip bit.
- R7: An arithmetic opcode raises `skip` exactly when opcode bit 0 is 1 and the carry or borrow out is 1.
- R8: Opcode 000100 skips when register == memory. Opcode 000101 skips when memory == immediate. Opcode 000001 skips when memory != immediate.
- R9: Opcode 000110 skips when register >= memory, taken as unsigned with no borrow. Opcode 000111 skips when memory >= immediate.
- R10: Compare opcodes assert none of `reg_we`, `mem_we` or `carry_we`.
- R11: Any other opcode asserts no write enable and no skip, and still retires with `done`=1.
- R12: The outputs of an instruction sampled at a rising edge with `issue`=1 appear after that edge, with `done`=1. In a cycle with `done`=0, all enables and `skip` are 0. Back-to-back issues retire on consecutive cycles.
- R13: `dst_row`, `dst_col` and `dst_reg` carry instr[9:8], instr[7:4] and instr[3:0] of the retiring instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Instruction present this cycle |
| instr | input | 16 | Instruction word |
| reg_nib | input | 4 | Register operand |
| mem_nib | input | 4 | Memory operand |
| carry_in | input | 1 | Current carry/borrow flag |
| done | output | 1 | An instruction retires this cycle |
| result | output | 4 | Arithmetic result |
| reg_we | output | 1 | Write result to register |
| mem_we | output | 1 | Write result to memory |
| carry_we | output | 1 | Update the carry/borrow flag |
| carry_out | output | 1 | New carry/borrow flag |
| skip | output | 1 | Skip the next instruction |
| dst_row | output | 2 | Memory row of the destination |
| dst_col | output | 4 | Memory column of the destination |
| dst_reg | output | 4 | Register number of the destination |

## Verification
The functions that can fall in the same cycle are a destination write and a skip request. A skipping add or subtract whose carry or borrow fires must write its result, update the flag and raise the skip in the same retire cycle. The bench provokes this with operands such as F plus 1 and 0 minus 1, with and without carry-in. It checks that all three outputs hold their expected values together, and that the non-skipping variant of the same operation writes with no skip. Back-to-back issues check that a skipping instruction is followed directly by a non-skipping one without its skip or enables leaking into the next retire cycle.

// File: rtl/nalu_pkg.sv
package nalu_pkg;

    localparam int DATA_W  = 4;
    localparam int INSTR_W = 16;
    localparam int OPC_W   = 6;
    localparam int ROW_W   = 2;
    localparam int COL_W   = 4;
    localparam int FLD_W   = 4;

    typedef enum logic [1:0] {
        CL_NONE  = 2'd0,
        CL_ARITH = 2'd1,
        CL_CMP   = 2'd2
    } op_class_e;

    typedef enum logic [1:0] {
        CMP_EQ = 2'd0,
        CMP_NE = 2'd1,
        CMP_GE = 2'd2
    } cmp_kind_e;

    typedef struct packed {
        op_class_e cls;
        logic      src_imm;   // operands are memory and immediate
        logic      sub;       // subtract instead of add
        logic      use_cin;   // consume flag as carry/borrow in
        logic      skip_flag; // skip on carry/borrow out
        logic      dest_reg;
        logic      dest_mem;
        cmp_kind_e cmp;
    } nalu_ctrl_t;

endpackage

// File: rtl/nalu_decode.sv
module nalu_decode
    import nalu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output nalu_ctrl_t       ctrl
);

    always_comb begin
        ctrl = '{cls: CL_NONE, src_imm: 1'b0, sub: 1'b0, use_cin: 1'b0,
                 skip_flag: 1'b0, dest_reg: 1'b0, dest_mem: 1'b0, cmp: CMP_EQ};
        if (opcode[5:4] == 2'b01) begin
            ctrl.cls       = CL_ARITH;
            ctrl.sub       = opcode[3];
            ctrl.src_imm   = opcode[2];
            ctrl.use_cin   = opcode[1];
            ctrl.skip_flag = opcode[0];
            ctrl.dest_reg  = ~opcode[2];
            ctrl.dest_mem  = opcode[2];
        end else begin
            unique case (opcode)
                6'b000100: begin ctrl.cls = CL_CMP; ctrl.sub = 1'b1; ctrl.cmp = CMP_EQ; end
                6'b000101: begin ctrl.cls = CL_CMP; ctrl.sub = 1'b1; ctrl.src_imm = 1'b1; ctrl.cmp = CMP_EQ; end
                6'b000001: begin ctrl.cls = CL_CMP; ctrl.sub = 1'b1; ctrl.src_imm = 1'b1; ctrl.cmp = CMP_NE; end
                6'b000110: begin ctrl.cls = CL_CMP; ctrl.sub = 1'b1; ctrl.cmp = CMP_GE; end
                6'b000111: begin ctrl.cls = CL_CMP; ctrl.sub = 1'b1; ctrl.src_imm = 1'b1; ctrl.cmp = CMP_GE; end
                default:   ctrl.cls = CL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/nalu_adder.sv
module nalu_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         flag_in,   // carry-in for add, borrow-in for subtract
    output logic [W-1:0] sum,
    output logic         flag_out,  // carry-out for add, borrow-out for subtract
    output logic         zero
);

    logic [W-1:0] b_eff;
    logic [W:0]   c;

    assign b_eff = sub ? ~b : b;
    assign c[0]  = sub ? ~flag_in : flag_in;

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        assign sum[gi]  = a[gi] ^ b_eff[gi] ^ c[gi];
        assign c[gi+1]  = (a[gi] & b_eff[gi]) | (c[gi] & (a[gi] ^ b_eff[gi]));
    end

    assign flag_out = sub ? ~c[W] : c[W];
    assign zero     = (sum == '0);

endmodule

// File: rtl/nalu_skip.sv
module nalu_skip
    import nalu_pkg::*;
(
    input  nalu_ctrl_t ctrl,
    input  logic       flag,
    input  logic       zero,
    output logic       skip
);

    always_comb begin
        skip = 1'b0;
        unique case (ctrl.cls)
            CL_ARITH: skip = ctrl.skip_flag & flag;
            CL_CMP: begin
                unique case (ctrl.cmp)
                    CMP_EQ:  skip = zero;
                    CMP_NE:  skip = ~zero;
                    CMP_GE:  skip = ~flag;
                    default: skip = 1'b0;
                endcase
            end
            default: skip = 1'b0;
        endcase
    end

endmodule

// File: rtl/nalu_core.sv
module nalu_core
    import nalu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  reg_nib,
    input  logic [DATA_W-1:0]  mem_nib,
    input  logic               carry_in,
    output logic               done,
    output logic [DATA_W-1:0]  result,
    output logic               reg_we,
    output logic               mem_we,
    output logic               carry_we,
    output logic               carry_out,
    output logic               skip,
    output logic [ROW_W-1:0]   dst_row,
    output logic [COL_W-1:0]   dst_col,
    output logic [FLD_W-1:0]   dst_reg
);

    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int ROW_LSB = OPC_LSB - ROW_W;
    localparam int COL_LSB = ROW_LSB - COL_W;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RETIRE = 1'b1
    } state_e;

    state_e state_q, state_d;

    nalu_ctrl_t        ctrl;
    logic [DATA_W-1:0] imm, op_a, op_b, sum;
    logic              flag_in, flag_out, zero, skip_c;

    nalu_decode u_dec (
        .opcode (instr[INSTR_W-1:OPC_LSB]),
        .ctrl   (ctrl)
    );

    assign imm     = instr[FLD_W-1:0];
    assign op_a    = ctrl.src_imm ? mem_nib : reg_nib;
    assign op_b    = ctrl.src_imm ? imm : mem_nib;
    assign flag_in = ctrl.use_cin & carry_in;

    nalu_adder #(.W(DATA_W)) u_add (
        .a        (op_a),
        .b        (op_b),
        .sub      (ctrl.sub),
        .flag_in  (flag_in),
        .sum      (sum),
        .flag_out (flag_out),
        .zero     (zero)
    );

    nalu_skip u_skip (
        .ctrl (ctrl),
        .flag (flag_out),
        .zero (zero),
        .skip (skip_c)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = issue ? ST_RETIRE : ST_IDLE;   // T_ISSUE
            ST_RETIRE: state_d = issue ? ST_RETIRE : ST_IDLE;   // T_CHAIN / T_DRAIN
            default:   state_d = ST_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            reg_we    <= 1'b0;
            mem_we    <= 1'b0;
            carry_we  <= 1'b0;
            carry_out <= 1'b0;
            skip      <= 1'b0;
            dst_row   <= '0;
            dst_col   <= '0;
            dst_reg   <= '0;
        end else if (issue) begin
            result    <= sum;
            reg_we    <= (ctrl.cls == CL_ARITH) & ctrl.dest_reg;
            mem_we    <= (ctrl.cls == CL_ARITH) & ctrl.dest_mem;
            carry_we  <= (ctrl.cls == CL_ARITH);
            carry_out <= flag_out;
            skip      <= skip_c;
            dst_row   <= instr[OPC_LSB-1:ROW_LSB];
            dst_col   <= instr[ROW_LSB-1:COL_LSB];
            dst_reg   <= instr[FLD_W-1:0];
        end else begin
            reg_we    <= 1'b0;
            mem_we    <= 1'b0;
            carry_we  <= 1'b0;
            skip      <= 1'b0;
        end
    end

    assign done = (state_q == ST_RETIRE);

    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && mem_we));                                      // R2
    AST_ISSUE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> done);                                           // R12
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(reg_we || mem_we || carry_we || skip));        // R12
    AST_FLAG_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        carry_we |-> (reg_we || mem_we));                          // R6
    AST_WRITE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || mem_we) |-> carry_we);                          // R10
    AST_CMP_ZERO_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.cls == CL_CMP && ctrl.cmp == CMP_EQ) |-> (skip_c == (op_a == op_b))); // R8

endmodule

// File: tb/nalu_core_tb.sv
module nalu_core_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [15:0] instr = '0;
    logic [3:0]  reg_nib = '0, mem_nib = '0;
    logic        carry_in = 1'b0;
    logic        done, reg_we, mem_we, carry_we, carry_out, skip;
    logic [3:0]  result, dst_col, dst_reg;
    logic [1:0]  dst_row;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nalu_core dut_i (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
        .reg_nib(reg_nib), .mem_nib(mem_nib), .carry_in(carry_in),
        .done(done), .result(result), .reg_we(reg_we), .mem_we(mem_we),
        .carry_we(carry_we), .carry_out(carry_out), .skip(skip),
        .dst_row(dst_row), .dst_col(dst_col), .dst_reg(dst_reg)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected behaviour from the requirements.
    task automatic model(input logic [15:0] ins, input int r, input int m, input int cf,
                         output int e_res, output int e_rwe, output int e_mwe,
                         output int e_cwe, output int e_cy, output int e_skip);
        int op, imm, a, b, cin, t;
        op = int'(ins[15:10]);
        imm = int'(ins[3:0]);
        e_res = 0; e_rwe = 0; e_mwe = 0; e_cwe = 0; e_cy = 0; e_skip = 0;
        cin = ((op & 2) != 0) ? cf : 0;
        if ((op >> 4) == 1) begin
            a = ((op & 4) != 0) ? m : r;
            b = ((op & 4) != 0) ? imm : m;
            if ((op & 8) == 0) begin
                t = a + b + cin;
                e_cy = (t > 15) ? 1 : 0;
            end else begin
                t = a - b - cin;
                e_cy = (t < 0) ? 1 : 0;
            end
            e_res = t & 15;
            e_rwe = ((op & 4) == 0) ? 1 : 0;
            e_mwe = 1 - e_rwe;
            e_cwe = 1;
            e_skip = ((op & 1) != 0) ? e_cy : 0;
        end else begin
            case (op)
                6'b000100: e_skip = (r == m) ? 1 : 0;
                6'b000101: e_skip = (m == imm) ? 1 : 0;
                6'b000001: e_skip = (m != imm) ? 1 : 0;
                6'b000110: e_skip = (r >= m) ? 1 : 0;
                6'b000111: e_skip = (m >= imm) ? 1 : 0;
                default:   e_skip = 0;
            endcase
        end
    endtask

    // Issue one instruction; issue stays high until idle() is called.
    task automatic apply(input string req, input logic [5:0] op, input logic [1:0] row,
                         input logic [3:0] col, input logic [3:0] fld,
                         input logic [3:0] r, input logic [3:0] m, input logic cf);
        int e_res, e_rwe, e_mwe, e_cwe, e_cy, e_skip;
        logic [15:0] ins;
        ins = {op, row, col, fld};
        model(ins, int'(r), int'(m), int'(cf), e_res, e_rwe, e_mwe, e_cwe, e_cy, e_skip);
        @(negedge clk);
        issue = 1'b1; instr = ins; reg_nib = r; mem_nib = m; carry_in = cf;
        @(posedge clk);
        #1;
        chk(req, "done", int'(done), 1);
        chk(req, "reg_we", int'(reg_we), e_rwe);
        chk(req, "mem_we", int'(mem_we), e_mwe);
        chk(req, "carry_we", int'(carry_we), e_cwe);
        chk(req, "skip", int'(skip), e_skip);
        if (e_cwe != 0) begin
            chk(req, "result", int'(result), e_res);
            chk(req, "carry_out", int'(carry_out), e_cy);
        end
        if (e_rwe != 0 || e_mwe != 0) begin
            chk("R13", "dst_row", int'(dst_row), int'(row));
            chk("R13", "dst_col", int'(dst_col), int'(col));
            chk("R13", "dst_reg", int'(dst_reg), int'(fld));
        end
    endtask

    task automatic idle();
        @(negedge clk);
        issue = 1'b0;
        @(posedge clk);
        #1;
        chk("R12", "idle done", int'(done), 0);
        chk("R12", "idle enables", int'({reg_we, mem_we, carry_we, skip}), 0);
    endtask

    task automatic t_reset();
        #1;
        chk("R1", "reset done", int'(done), 0);
        chk("R1", "reset enables", int'({reg_we, mem_we, carry_we, skip}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "post-reset enables", int'({done, reg_we, mem_we, carry_we, skip}), 0);
    endtask

    task automatic t_add_reg();   // R2 R7 R6
        apply("R2", 6'b010000, 2'd1, 4'd3, 4'd5, 4'd7, 4'd6, 1'b1);
        apply("R2", 6'b010000, 2'd2, 4'd9, 4'd1, 4'd15, 4'd1, 1'b0);
        apply("R7", 6'b010001, 2'd3, 4'd0, 4'd2, 4'd15, 4'd1, 1'b0);
        apply("R7", 6'b010001, 2'd0, 4'd1, 4'd2, 4'd3, 4'd4, 1'b1);
        apply("R2", 6'b010010, 2'd1, 4'd2, 4'd3, 4'd7, 4'd8, 1'b1);
        apply("R6", 6'b010011, 2'd0, 4'd4, 4'd6, 4'd15, 4'd0, 1'b1);
        apply("R2", 6'b010011, 2'd0, 4'd4, 4'd6, 4'd15, 4'd0, 1'b0);
        idle();
    endtask

    task automatic t_add_imm();   // R3
        apply("R3", 6'b010100, 2'd2, 4'd5, 4'd9, 4'd0, 4'd8, 1'b1);
        apply("R3", 6'b010101, 2'd1, 4'd6, 4'd9, 4'd0, 4'd8, 1'b0);
        apply("R3", 6'b010110, 2'd3, 4'd7, 4'd15, 4'd2, 4'd0, 1'b1);
        apply("R3", 6'b010111, 2'd0, 4'd8, 4'd1, 4'd2, 4'd14, 1'b1);
        idle();
    endtask

    task automatic t_sub_reg();   // R4
        apply("R4", 6'b011000, 2'd1, 4'd1, 4'd1, 4'd9, 4'd4, 1'b1);
        apply("R4", 6'b011001, 2'd1, 4'd2, 4'd1, 4'd0, 4'd1, 1'b0);
        apply("R4", 6'b011010, 2'd2, 4'd3, 4'd4, 4'd5, 4'd5, 1'b1);
        apply("R4", 6'b011011, 2'd3, 4'd4, 4'd4, 4'd5, 4'd4, 1'b1);
        apply("R4", 6'b011011, 2'd3, 4'd4, 4'd4, 4'd5, 4'd4, 1'b0);
        idle();
    endtask

    task automatic t_sub_imm();   // R5
        apply("R5", 6'b011100, 2'd0, 4'd12, 4'd3, 4'd0, 4'd10, 1'b1);
        apply("R5", 6'b011101, 2'd1, 4'd13, 4'd11, 4'd0, 4'd10, 1'b0);
        apply("R5", 6'b011110, 2'd2, 4'd14, 4'd4, 4'd0, 4'd4, 1'b1);
        apply("R5", 6'b011111, 2'd3, 4'd15, 4'd0, 4'd0, 4'd0, 1'b1);
        idle();
    endtask

    task automatic t_eq_cmp();    // R8 R10
        apply("R8", 6'b000100, 2'd0, 4'd0, 4'd1, 4'd6, 4'd6, 1'b1);
        apply("R8", 6'b000100, 2'd0, 4'd0, 4'd1, 4'd6, 4'd7, 1'b0);
        apply("R8", 6'b000101, 2'd0, 4'd0, 4'd9, 4'd2, 4'd9, 1'b0);
        apply("R8", 6'b000101, 2'd0, 4'd0, 4'd9, 4'd2, 4'd8, 1'b1);
        apply("R10", 6'b000001, 2'd0, 4'd0, 4'd3, 4'd2, 4'd8, 1'b1);
        apply("R8", 6'b000001, 2'd0, 4'd0, 4'd8, 4'd2, 4'd8, 1'b0);
        idle();
    endtask

    task automatic t_ge_cmp();    // R9
        apply("R9", 6'b000110, 2'd0, 4'd0, 4'd0, 4'd5, 4'd5, 1'b1);
        apply("R9", 6'b000110, 2'd0, 4'd0, 4'd0, 4'd4, 4'd5, 1'b0);
        apply("R9", 6'b000110, 2'd0, 4'd0, 4'd0, 4'd15, 4'd0, 1'b1);
        apply("R9", 6'b000111, 2'd0, 4'd0, 4'd7, 4'd0, 4'd6, 1'b1);
        apply("R9", 6'b000111, 2'd0, 4'd0, 4'd7, 4'd0, 4'd7, 1'b0);
        apply("R9", 6'b000111, 2'd0, 4'd0, 4'd0, 4'd0, 4'd15, 1'b0);
        idle();
    endtask

    task automatic t_unlisted();  // R11
        apply("R11", 6'b000000, 2'd0, 4'd0, 4'd0, 4'd3, 4'd3, 1'b1);
        apply("R11", 6'b000010, 2'd0, 4'd0, 4'd0, 4'd3, 4'd3, 1'b1);
        apply("R11", 6'b000011, 2'd0, 4'd0, 4'd0, 4'd0, 4'd15, 1'b1);
        apply("R11", 6'b110100, 2'd1, 4'd1, 4'd1, 4'd15, 4'd15, 1'b1);
        apply("R11", 6'b111111, 2'd1, 4'd1, 4'd1, 4'd15, 4'd15, 1'b1);
        idle();
    endtask

    task automatic t_chain();     // R12 R7
        apply("R12", 6'b010001, 2'd1, 4'd2, 4'd3, 4'd15, 4'd15, 1'b0);
        apply("R12", 6'b010000, 2'd2, 4'd3, 4'd4, 4'd1, 4'd1, 1'b0);
        apply("R12", 6'b000100, 2'd0, 4'd0, 4'd0, 4'd2, 4'd2, 1'b0);
        apply("R12", 6'b011100, 2'd3, 4'd5, 4'd1, 4'd2, 4'd2, 1'b1);
        idle();
        idle();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R12 watchdog expired: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_add_reg();
        t_add_imm();
        t_sub_reg();
        t_sub_imm();
        t_eq_cmp();
        t_ge_cmp();
        t_unlisted();
        t_chain();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule